// File: doc/BRIEF.md
# Register-Steered Prefetch Burst Controller

This block sits between a processor's load/store port and the line-fill logic of a data cache. It decides which word addresses are fetched when an access misses. Every access carries the number of the base register it was addressed through. A small policy table, indexed by that number, holds the fetch behaviour for the access. Software programs the table through a hint port, so several base registers can follow different patterns at the same time. One register can walk a bitmap row by row at the frame's pitch, for example 32 words for a 1024-pixel-wide one-bit frame. Another can stream consecutive words, and a third can touch scattered locations without pulling in any neighbours.

An accepted miss starts a burst on a valid/ready request channel. The missed word is always sent first. Up to three further words follow, one per accepted handshake, and each request is flagged as installing or not installing in the cache. A second miss is held off until the last request of the current burst has been taken.

Top module: `stride_prefetch_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, `req_valid` is 0, and every one of the eight table entries behaves as sequential mode.
- R2: Mode code 00 (sequential): a miss on word A issues A, A+1, A+2 and A+3 in that order, all with `req_alloc` = 1. The stored stride is ignored.
- R3: Mode code 01 (strided): a miss on word A with stored stride S (a 12-bit unsigned word count) issues A, A+S, A+2S and A+3S in that order, all with `req_alloc` = 1.
- R4: Mode code 10 (no prefetch): a miss issues only A, with `req_alloc` = 1.
- R5: Mode code 11 (no allocate): a miss issues only A, with `req_alloc` = 0.
- R6: A hint (`hint_valid` = 1) stores the mode and stride for register `hint_reg`. The entry keeps them until a later hint to the same register, and leaves the other entries unchanged.
- R7: The policy applied to a miss is the entry of its `miss_reg`, so different registers keep independent behaviours.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_addr` and `req_alloc` hold. At most one request is taken per cycle.
- R9: `miss_ready` is 0 from the cycle after a miss is accepted until the cycle after the last request of its burst is taken.
- R10: Request addresses wrap modulo 2^AW.
- R11: In strided mode with stride 0, only A is issued. No request ever repeats the missed address within a burst.
- R12: When a hint and a miss to the same register arrive in the same cycle, the miss uses the entry as it was before the hint. The hint applies from the next miss on.
- R13: The first request, carrying the missed address, is valid in the cycle right after the miss is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Write one policy entry |
| hint_reg | input | 3 | Register number of the entry written |
| hint_mode | input | 2 | Mode code: 00 sequential, 01 strided, 10 none, 11 no allocate |
| hint_stride | input | 12 | Stride in words |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | The block can take a miss |
| miss_reg | input | 3 | Base register number of the missing access |
| miss_addr | input | 32 | Word address that missed |
| req_valid | output | 1 | A fetch request is presented |
| req_ready | input | 1 | The fill side takes the request |
| req_addr | output | 32 | Word address to fetch |
| req_alloc | output | 1 | 1: install the word in the cache; 0: return it only |

## Verification
A miss accepted at a clock edge shows its demand word on the request channel before the next edge, one register stage later. Each following prefetch address appears one cycle after the previous request was taken. A hint is registered at its edge and affects only misses accepted after that edge, and `miss_ready` rises one cycle after the final handshake. The bench drives inputs and samples outputs at the falling edge. It checks the demand address at the first falling edge after acceptance, collects every request taken while `req_ready` is high, and under back-pressure compares the held address across stalled cycles.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        PM_SEQ     = 2'b00,
        PM_STRIDE  = 2'b01,
        PM_NONE    = 2'b10,
        PM_NOALLOC = 2'b11
    } pf_mode_e;
endpackage

// File: rtl/spf_policy_table.sv
module spf_policy_table
    import spf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int SW   = 12,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [1:0]    wr_mode,
    input  logic [SW-1:0] wr_stride,
    input  logic [RW-1:0] rd_idx,
    output pf_mode_e      rd_mode,
    output logic [SW-1:0] rd_stride
);
    typedef struct packed {
        logic [NREG-1:0][1:0]    mode;
        logic [NREG-1:0][SW-1:0] stride;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_idx == RW'(g));
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                tbl_d.mode[i]   = wr_mode;
                tbl_d.stride[i] = wr_stride;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                tbl_q.mode[i]   <= PM_SEQ;
                tbl_q.stride[i] <= SW'(1);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Read uses the registered table: a same-cycle write is not seen.
    assign rd_mode   = pf_mode_e'(tbl_q.mode[rd_idx]);
    assign rd_stride = tbl_q.stride[rd_idx];

    AST_HINT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q.mode[$past(wr_idx)] == $past(wr_mode)) &&
                  (tbl_q.stride[$past(wr_idx)] == $past(wr_stride))); // R6
endmodule

// File: rtl/spf_burst_gen.sv
module spf_burst_gen
    import spf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SW       = 12,
    parameter int PF_DEPTH = 3,
    localparam int CW      = $clog2(PF_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  pf_mode_e      mode,
    input  logic [SW-1:0] stride,
    input  logic          req_ready,
    output logic          busy,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_alloc
);
    typedef struct packed {
        logic          busy;
        logic          first;
        logic          alloc;
        logic [CW-1:0] left;
        logic [AW-1:0] addr;
        logic [AW-1:0] base;
        logic [AW-1:0] step;
    } st_t;

    st_t s_d, s_q;
    logic [AW-1:0] stride_ext;

    assign stride_ext = {{(AW-SW){1'b0}}, stride};

    always_comb begin
        s_d = s_q;
        if (start && !s_q.busy) begin
            s_d.busy  = 1'b1;
            s_d.first = 1'b1;
            s_d.addr  = start_addr;
            s_d.base  = start_addr;
            s_d.alloc = (mode != PM_NOALLOC);
            s_d.step  = (mode == PM_SEQ) ? AW'(1) : stride_ext;
            unique case (mode)
                PM_SEQ:    s_d.left = CW'(PF_DEPTH);
                PM_STRIDE: s_d.left = (stride == '0) ? '0 : CW'(PF_DEPTH);
                default:   s_d.left = '0;
            endcase
        end else if (s_q.busy && req_ready) begin
            s_d.first = 1'b0;
            if (s_q.left == '0) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.addr = s_q.addr + s_q.step;
                s_d.left = s_q.left - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign req_valid = s_q.busy;
    assign req_addr  = s_q.addr;
    assign req_alloc = s_q.alloc;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_alloc)); // R8
    AST_NO_SELF_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !s_q.first |-> req_addr != s_q.base); // R11
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy); // R9
endmodule

// File: rtl/stride_prefetch_ctrl.sv
module stride_prefetch_ctrl
    import spf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SW       = 12,
    parameter int NREG     = 8,
    parameter int PF_DEPTH = 3,
    localparam int RW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hint_valid,
    input  logic [RW-1:0] hint_reg,
    input  logic [1:0]    hint_mode,
    input  logic [SW-1:0] hint_stride,
    input  logic          miss_valid,
    output logic          miss_ready,
    input  logic [RW-1:0] miss_reg,
    input  logic [AW-1:0] miss_addr,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic          req_alloc
);
    pf_mode_e      pol_mode;
    logic [SW-1:0] pol_stride;
    logic          gen_busy;
    logic          accept;

    spf_policy_table #(.NREG(NREG), .SW(SW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hint_valid),
        .wr_idx    (hint_reg),
        .wr_mode   (hint_mode),
        .wr_stride (hint_stride),
        .rd_idx    (miss_reg),
        .rd_mode   (pol_mode),
        .rd_stride (pol_stride)
    );

    assign miss_ready = !gen_busy;
    assign accept     = miss_valid && miss_ready;

    spf_burst_gen #(.AW(AW), .SW(SW), .PF_DEPTH(PF_DEPTH)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .start_addr (miss_addr),
        .mode       (pol_mode),
        .stride     (pol_stride),
        .req_ready  (req_ready),
        .busy       (gen_busy),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_alloc  (req_alloc)
    );

    AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> req_valid && (req_addr == $past(miss_addr))); // R13
    AST_MISS_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !miss_ready); // R9
    AST_NOALLOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_alloc |=> !req_valid); // R5
endmodule

// File: tb/stride_prefetch_ctrl_test.sv
`timescale 1ns/1ps
module stride_prefetch_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hint_valid = 1'b0;
    logic [2:0]  hint_reg = '0;
    logic [1:0]  hint_mode = '0;
    logic [11:0] hint_stride = '0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [2:0]  miss_reg = '0;
    logic [31:0] miss_addr = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic        req_alloc;

    int n_cmp = 0;
    int n_err = 0;
    logic [31:0] got_addr [8];
    logic        got_alloc [8];
    int          got_n;

    always #2 clk = ~clk;

    stride_prefetch_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_reg(hint_reg), .hint_mode(hint_mode),
        .hint_stride(hint_stride),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_reg(miss_reg),
        .miss_addr(miss_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_alloc(req_alloc)
    );

    typedef struct packed {
        logic [2:0]  rg;
        logic [1:0]  md;
        logic [11:0] st;
        logic [31:0] a;
        logic [31:0] cnt;
        logic [31:0] step;
        logic        al;
        logic [31:0] rq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd1, 2'b00, 12'd7,    32'h0000_0100, 32'd4, 32'd1,    1'b1, 32'd2},
        '{3'd2, 2'b01, 12'd32,   32'h0000_2000, 32'd4, 32'd32,   1'b1, 32'd3},
        '{3'd3, 2'b10, 12'd9,    32'h0000_0055, 32'd1, 32'd0,    1'b1, 32'd4},
        '{3'd4, 2'b11, 12'd9,    32'h0000_0077, 32'd1, 32'd0,    1'b0, 32'd5},
        '{3'd5, 2'b01, 12'hFFF,  32'h0000_0010, 32'd4, 32'd4095, 1'b1, 32'd3},
        '{3'd6, 2'b01, 12'd0,    32'h0000_0030, 32'd1, 32'd0,    1'b1, 32'd11}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_hint(input logic [2:0] r, input logic [1:0] m, input logic [11:0] s);
        hint_valid = 1'b1; hint_reg = r; hint_mode = m; hint_stride = s;
        @(negedge clk);
        hint_valid = 1'b0;
    endtask

    // Presents a miss; returns at the first falling edge after acceptance.
    task automatic issue_miss(input logic [2:0] r, input logic [31:0] a);
        miss_valid = 1'b1; miss_reg = r; miss_addr = a;
        while (!miss_ready) @(negedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        chk(req_valid === 1'b1, "R13", "first request valid", {31'd0, req_valid}, 32'd1);
        chk(req_addr === a, "R13", "first request address", req_addr, a);
    endtask

    task automatic collect(input bit bp);
        logic [31:0] held = '0;
        bit stalled = 1'b0;
        got_n = 0;
        for (int c = 0; c < 16; c++) begin
            req_ready = bp ? c[0] : 1'b1;
            if (stalled) begin
                chk(req_addr === held, "R8", "address held under stall", req_addr, held);
            end
            stalled = 1'b0;
            if (req_valid) begin
                chk(miss_ready === 1'b0, "R9", "miss_ready low during burst", {31'd0, miss_ready}, 32'd0);
                if (req_ready) begin
                    if (got_n < 8) begin
                        got_addr[got_n]  = req_addr;
                        got_alloc[got_n] = req_alloc;
                    end
                    got_n++;
                end else begin
                    stalled = 1'b1;
                    held = req_addr;
                end
            end
            @(negedge clk);
        end
        req_ready = 1'b1;
        chk(miss_ready === 1'b1, "R9", "miss_ready back after burst", {31'd0, miss_ready}, 32'd1);
    endtask

    task automatic expect_burst(input string req, input logic [31:0] a, input int cnt,
                                input logic [31:0] step, input logic al);
        chk(got_n == cnt, req, "request count", 32'(got_n), 32'(cnt));
        for (int i = 0; i < cnt && i < got_n; i++) begin
            logic [31:0] e;
            e = a + 32'(i) * step;
            chk(got_addr[i] === e, req, "request address", got_addr[i], e);
            chk(got_alloc[i] === al, req, "alloc flag", {31'd0, got_alloc[i]}, {31'd0, al});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_valid === 1'b0, "R1", "req_valid in reset", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid === 1'b0, "R1", "req_valid after reset", {31'd0, req_valid}, 32'd0);
        chk(miss_ready === 1'b1, "R1", "miss_ready after reset", {31'd0, miss_ready}, 32'd1);

        // R1: untouched entries act sequential
        issue_miss(3'd7, 32'h40); collect(1'b0);
        expect_burst("R1", 32'h40, 4, 32'd1, 1'b1);
        issue_miss(3'd2, 32'h900); collect(1'b0);
        expect_burst("R1", 32'h900, 4, 32'd1, 1'b1);

        // Vector table: R2 R3 R4 R5 R11
        for (int v = 0; v < 6; v++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[v].rq);
            send_hint(VECS[v].rg, VECS[v].md, VECS[v].st);
            issue_miss(VECS[v].rg, VECS[v].a);
            collect(1'b0);
            expect_burst(rq, VECS[v].a, int'(VECS[v].cnt), VECS[v].step, VECS[v].al);
        end

        // R6/R7: entries persist and stay independent
        issue_miss(3'd2, 32'h3000); collect(1'b0);
        expect_burst("R7", 32'h3000, 4, 32'd32, 1'b1);
        issue_miss(3'd1, 32'h3000); collect(1'b0);
        expect_burst("R6", 32'h3000, 4, 32'd1, 1'b1);
        issue_miss(3'd4, 32'h3100); collect(1'b0);
        expect_burst("R7", 32'h3100, 1, 32'd0, 1'b0);

        // R10: wrap
        issue_miss(3'd2, 32'hFFFF_FFF0); collect(1'b0);
        expect_burst("R10", 32'hFFFF_FFF0, 4, 32'd32, 1'b1);

        // R8: back-pressure
        issue_miss(3'd5, 32'h700); collect(1'b1);
        expect_burst("R8", 32'h700, 4, 32'd4095, 1'b1);

        // R12: same-cycle hint and miss on register 0
        hint_valid = 1'b1; hint_reg = 3'd0; hint_mode = 2'b10; hint_stride = 12'd5;
        miss_valid = 1'b1; miss_reg = 3'd0; miss_addr = 32'h500;
        @(negedge clk);
        hint_valid = 1'b0; miss_valid = 1'b0;
        collect(1'b0);
        expect_burst("R12", 32'h500, 4, 32'd1, 1'b1);
        issue_miss(3'd0, 32'h600); collect(1'b0);
        expect_burst("R12", 32'h600, 1, 32'd0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule